// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock that is driven to an SD card from the host clock. A 16-bit clock-control word selects a power-of-two divide ratio through a one-hot field, switches the card clock on or off, and turns on a power-save mode. In power-save mode the card clock is stopped whenever the transfer engine reports that the bus is idle. The output is a registered divided signal. A one-cycle strobe marks the end of each full card-clock period.

The core is a four-state machine: `ST_OFF` (clock disabled, output low), `ST_PARK` (enabled but parked low by power save), `ST_LOW` (running, low phase) and `ST_HIGH` (running, high phase). The transitions are:
- `OFF->LOW`: enable set and not parked.
- `OFF->PARK`: enable set while power save and idle are both true.
- `PARK->LOW`: the bus becomes busy or power save is cleared.
- `LOW->HIGH`: the low half-period count is reached.
- `HIGH->LOW`: the high half-period count is reached. This is the rollover.
- `HIGH->PARK`: the high half-period count is reached while parking is requested.
- `LOW->PARK`: parking is requested during the low phase.
- `any->OFF`: enable is cleared.

The counter is cleared on every state change. The requested ratio is copied into the active ratio register only on entry into `ST_LOW`. A ratio change therefore never shortens a phase that is already under way.

Top module: `sdclk_gen`

## Requirements
- R1: Control bits [7:0] select the divide ratio N: all zero gives N=2, and highest set bit k gives N=2^(k+2). The card clock is high for N/2 host cycles and low for N/2 host cycles.
- R2: While control bit 8 (enable) is 0, the card clock is held low from the next cycle and no rollover strobe is issued.
- R3: With control bit 9 (power save) set and the bus-idle input high, the card clock stops low. A high phase that is under way is first completed at full width.
- R4: For a 67,027,964 Hz host clock and a 400 kHz target, the slowest allowed ratio that does not exceed the target is 256, selected by field bit 6. This gives a half-period of 128 host cycles.
- R5: After reset the card clock is low and the rollover strobe is low.
- R6: The rollover strobe is high for exactly those cycles in which the card clock has just fallen at the end of a full high phase.
- R7: If more than one divider bit is set, the highest set bit alone decides the ratio.
- R8: A ratio change takes effect only at the next falling edge of the card clock. The high phase that is under way keeps the old width, and the next low phase uses the new ratio.
- R9: When power save releases the clock, the low phase starts with a cleared counter. Exactly N/2 low cycles precede the first high phase, which also has full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 16 | Clock-control word: [7:0] one-hot divider, [8] enable, [9] power save |
| bus_idle_i | input | 1 | High when no command or data transfer is active |
| card_clk_o | output | 1 | Divided card clock |
| rollover_o | output | 1 | One-cycle strobe at each falling edge that closes a full period |

## Verification
The hardest cases to reach from the ports are requests that land inside a phase: a ratio change, or a park request, made while the card clock is high. The bench reaches them by watching the card clock at each falling host edge. On the first sample that shows the card clock high, it changes the control word or the idle input. It then counts the high samples of that same phase, and counts the low samples that follow. The phase boundary is therefore known to the cycle, without any view of the counter.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    // Number of one-hot divider bits in the control word.
    localparam int unsigned DIV_BITS = 8;
    // Half-period counter width: the largest half period is 2**DIV_BITS.
    localparam int unsigned CNT_W    = DIV_BITS;

    // Positions of the control bits.
    localparam int unsigned EN_BIT   = 8;
    localparam int unsigned PS_BIT   = 9;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_PARK = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } clk_state_e;

endpackage

// File: rtl/sdclk_ratio_dec.sv
// Priority decode of the one-hot divider field into (half period - 1).
module sdclk_ratio_dec
    import sdclk_pkg::*;
#(
    parameter int unsigned SEL_W = DIV_BITS,
    parameter int unsigned OUT_W = CNT_W
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [OUT_W-1:0] half_m1_o
);

    // Candidate value for each select bit: bit i gives half period 2**(i+1).
    logic [OUT_W-1:0] cand [SEL_W];

    genvar g;
    generate
        for (g = 0; g < SEL_W; g++) begin : g_cand
            assign cand[g] = OUT_W'((64'd1 << (g + 1)) - 64'd1);
        end
    endgenerate

    // Scan upward so that the highest set bit wins.
    always_comb begin
        half_m1_o = '0;
        for (int i = 0; i < SEL_W; i++) begin
            if (sel_i[i]) begin
                half_m1_o = cand[i];
            end
        end
    end

endmodule

// File: rtl/sdclk_half_cnt.sv
// Counts host cycles within one card-clock half period.
module sdclk_half_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         at_end_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign at_end_o = (cnt_q == limit_i);

endmodule

// File: rtl/sdclk_phase_fsm.sv
// Phase state machine of the card clock.
module sdclk_phase_fsm
    import sdclk_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       park_i,
    input  logic       at_end_i,
    output clk_state_e state_o,
    output logic       load_o,
    output logic       clr_o,
    output logic       card_clk_o,
    output logic       roll_o
);

    clk_state_e state_q, state_d;
    logic       roll_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) begin
                    state_d = park_i ? ST_PARK : ST_LOW;
                end
            end
            ST_PARK: begin
                if (!en_i) begin
                    state_d = ST_OFF;
                end else if (!park_i) begin
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (!en_i) begin
                    state_d = ST_OFF;
                end else if (park_i) begin
                    state_d = ST_PARK;
                end else if (at_end_i) begin
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (!en_i) begin
                    state_d = ST_OFF;
                end else if (at_end_i) begin
                    state_d = park_i ? ST_PARK : ST_LOW;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register and registered rollover strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            roll_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            roll_q  <= (state_q == ST_HIGH) && en_i && at_end_i;
        end
    end

    // Outputs.
    always_comb begin
        state_o    = state_q;
        card_clk_o = (state_q == ST_HIGH);
        roll_o     = roll_q;
        load_o     = (state_d == ST_LOW) && (state_q != ST_LOW);
        clr_o      = (state_d != state_q) || (state_q == ST_OFF)
                     || (state_q == ST_PARK);
    end

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [15:0] ctrl_i,
    input  logic        bus_idle_i,
    output logic        card_clk_o,
    output logic        rollover_o
);

    logic [CNT_W-1:0] half_req;
    logic [CNT_W-1:0] half_act_q;
    logic             load;
    logic             clr;
    logic             at_end;
    logic             park;
    clk_state_e       state;

    assign park = ctrl_i[PS_BIT] && bus_idle_i;

    sdclk_ratio_dec #(
        .SEL_W (DIV_BITS),
        .OUT_W (CNT_W)
    ) u_dec (
        .sel_i     (ctrl_i[DIV_BITS-1:0]),
        .half_m1_o (half_req)
    );

    // The active ratio is updated only on entry into the low phase.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            half_act_q <= '0;
        end else if (load) begin
            half_act_q <= half_req;
        end
    end

    sdclk_half_cnt #(
        .W (CNT_W)
    ) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (clr),
        .limit_i  (half_act_q),
        .at_end_o (at_end)
    );

    sdclk_phase_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (ctrl_i[EN_BIT]),
        .park_i     (park),
        .at_end_i   (at_end),
        .state_o    (state),
        .load_o     (load),
        .clr_o      (clr),
        .card_clk_o (card_clk_o),
        .roll_o     (rollover_o)
    );

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
    import sdclk_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic [15:0]      ctrl_i,
    input logic             bus_idle_i,
    input logic             card_clk_o,
    input logic             rollover_o,
    input logic [CNT_W-1:0] half_act_q
);

    // R2: a cleared enable forces the clock low in the next cycle.
    a_r2_disable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_i[EN_BIT] |=> !card_clk_o);

    // R2: no strobe while disabled.
    a_r2_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_i[EN_BIT] |=> !rollover_o);

    // R3: a parked low clock stays low.
    a_r3_parked_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_i[PS_BIT] && bus_idle_i && !card_clk_o) |=> !card_clk_o);

    // R6: the strobe appears only on a falling edge of the card clock.
    a_r6_strobe_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rollover_o |-> ($past(card_clk_o) && !card_clk_o));

    // R8: the active ratio does not change while the clock is high.
    a_r8_ratio_held_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (card_clk_o && $past(card_clk_o)) |-> $stable(half_act_q));

endmodule

bind sdclk_gen sdclk_gen_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl_i),
    .bus_idle_i (bus_idle_i),
    .card_clk_o (card_clk_o),
    .rollover_o (rollover_o),
    .half_act_q (half_act_q)
);

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl = 16'h0000;
    logic        idle = 1'b0;
    logic        cclk;
    logic        roll;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    sdclk_gen u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ctrl_i     (ctrl),
        .bus_idle_i (idle),
        .card_clk_o (cclk),
        .rollover_o (roll)
    );

    localparam int NV = 11;
    localparam logic [15:0] V_CTRL [NV] = '{16'h0100, 16'h0101, 16'h0102,
        16'h0104, 16'h0108, 16'h0110, 16'h0120, 16'h0140, 16'h0180,
        16'h0103, 16'h01FF};
    localparam int V_HALF [NV] = '{1, 2, 4, 8, 16, 32, 64, 128, 256, 4, 256};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for a rising card clock, then count the high and low samples.
    task automatic measure(output int hw, output int lw);
        int guard = 0;
        hw = 0;
        lw = 0;
        while (cclk && guard < 2000) begin @(negedge clk); guard++; end
        while (!cclk && guard < 2000) begin @(negedge clk); guard++; end
        while (cclk && guard < 4000) begin hw++; @(negedge clk); guard++; end
        while (!cclk && guard < 4000) begin lw++; @(negedge clk); guard++; end
    endtask

    // Count high samples from the current one, then the low samples after it.
    task automatic count_from_high(output int hw, output int lw);
        int guard = 0;
        hw = 0;
        lw = 0;
        while (cclk && guard < 2000) begin hw++; @(negedge clk); guard++; end
        while (!cclk && guard < 2000) begin lw++; @(negedge clk); guard++; end
    endtask

    task automatic wait_high();
        int guard = 0;
        while (!cclk && guard < 2000) begin @(negedge clk); guard++; end
    endtask

    initial begin
        int hw, lw, n, bad, ones;
        logic prev;

        // R5: reset state.
        repeat (3) @(negedge clk);
        check("R5 clk low in reset", int'(cclk), 0);
        check("R5 strobe low in reset", int'(roll), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 clk low after reset", int'(cclk), 0);

        // R1 and R7: table of ratios.
        for (int i = 0; i < NV; i++) begin
            ctrl = 16'h0000;
            repeat (3) @(negedge clk);
            check("R2 disabled between vectors", int'(cclk), 0);
            ctrl = V_CTRL[i];
            measure(hw, lw);
            measure(hw, lw);
            check("R1/R7 high width", hw, V_HALF[i]);
            check("R1/R7 low width", lw, V_HALF[i]);
        end

        // R4: ratio for the identification clock, computed here.
        n = 2;
        while ((67027964 / n) > 400000 || (67027964 % n != 0 && 67027964 / n == 400000))
            n = n * 2;
        check("R4 ratio", n, 256);
        ctrl = 16'h0000;
        repeat (3) @(negedge clk);
        ctrl = 16'h0100 | (16'h1 << ($clog2(n) - 2));
        measure(hw, lw);
        check("R4 half period", hw, n / 2);

        // R2: disabled with divider bits set stays low, no strobe.
        ctrl = 16'h00FF;
        @(negedge clk);
        bad = 0;
        for (int k = 0; k < 600; k++) begin
            if (cclk || roll) bad++;
            @(negedge clk);
        end
        check("R2 held low while disabled", bad, 0);

        // R6: the strobe matches each falling edge of a full period.
        ctrl = 16'h0101;
        repeat (10) @(negedge clk);
        prev = cclk;
        bad = 0;
        ones = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (roll != (prev && !cclk)) bad++;
            if (roll) ones++;
            prev = cclk;
        end
        check("R6 strobe mismatches", bad, 0);
        check("R6 strobe count", ones, 16);

        // R8: change 8 -> 1 in a high phase: old high, new low.
        ctrl = 16'h0104;
        measure(hw, lw);
        wait_high();
        ctrl = 16'h0100;
        count_from_high(hw, lw);
        check("R8 high keeps old width", hw, 8);
        check("R8 next low uses new ratio", lw, 1);
        // R8: change 1 -> 8 in a low phase: next high still 1, then 8.
        measure(hw, lw);
        ctrl = 16'h0104;
        wait_high();
        count_from_high(hw, lw);
        check("R8 high after low-phase change", hw, 1);
        measure(hw, lw);
        check("R8 later high uses new ratio", hw, 8);

        // R3: power save with idle bus parks the clock low.
        ctrl = 16'h0000;
        repeat (3) @(negedge clk);
        idle = 1'b1;
        ctrl = 16'h0301;
        bad = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (cclk) bad++;
        end
        check("R3 parked while idle", bad, 0);

        // R9: release from park: N/2 low samples, then full high.
        idle = 1'b0;
        lw = 0;
        begin
            int guard = 0;
            @(negedge clk);
            while (!cclk && guard < 100) begin lw++; @(negedge clk); guard++; end
        end
        check("R9 low before first high", lw, 2);
        count_from_high(hw, lw);
        check("R9 first high width", hw, 2);

        // R3: park request during a high phase completes that phase.
        ctrl = 16'h0302;
        measure(hw, lw);
        wait_high();
        idle = 1'b1;
        count_from_high(hw, lw);
        check("R3 high completed before park", hw, 4);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            if (cclk) bad++;
            @(negedge clk);
        end
        check("R3 stays parked", bad, 0);

        // R5: reset in the middle of a run.
        idle = 1'b0;
        ctrl = 16'h0100;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        ctrl = 16'h0000;
        @(negedge clk);
        check("R5 clk low on reset", int'(cclk), 0);
        check("R5 strobe low on reset", int'(roll), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule